// File: doc/BRIEF.md
# LVDT Ratiometric Excitation and Demodulator

This block drives the primary winding of a linear variable differential transformer and reads back the two secondary windings. Both jobs run from one clock. A phase accumulator steps through a quarter-wave sine table and sends a signed code to an external DAC on every excitation step. Samples of the two secondaries arrive from an external ADC, each tagged with the coil it belongs to.

Over each frame the block adds up the absolute value of every sample, keeping a separate total for each coil. This gives one magnitude estimate per coil. At every frame boundary the two totals are latched and a sequential divider computes the ratio (A−B)/(A+B). The divider runs during the following frame. The result appears at the next boundary as a signed Q1.15 position with a one-cycle strobe.

The ratio does not change when the excitation amplitude drifts, because that drift scales both coils alike. When both totals are zero there is no ratio to form. In that case the block keeps the last position and raises a fault flag. The frame length is set to give the 80 Hz update rate, for example 12.5 ms worth of clocks.

Top module: `lvdt_ratio_demod`

## Requirements
- R1: An excitation step occurs every EXC_DIV clocks. On each step, exc_code takes the sine value of the current phase, and then the phase (PHASE_W bits, starting at 0 after reset) advances by PHASE_INC modulo 2^PHASE_W. Between steps exc_code holds its value.
- R2: The sine value is computed from the phase. Its top 2 bits give the quadrant k, and the next QBITS bits give the address a. Let Q = 2^QBITS and H = 2Q. The table index is i = a in quadrants 0 and 2, and i = Q − a in quadrants 1 and 3. The magnitude is L(i) = floor(AMP·16·i·(H−i) / (5H² − 4·i·(H−i))), with AMP = 2^(EXC_W−1) − 1. The code is −L(i) in quadrants 2 and 3 and +L(i) otherwise.
- R3: A sample counts only in a cycle where adc_valid is 1. adc_coil = 0 adds it to the coil A total and adc_coil = 1 adds it to the coil B total. The amount added is the absolute value of the two's-complement adc_data, so the most negative code adds 2^(ADC_W−1). Samples with adc_valid = 0 have no effect.
- R4: Frame boundaries fall every FRAME_CLKS clocks, and the first boundary falls FRAME_CLKS clocks after reset is released. A sample presented in the last cycle of a frame belongs to that frame. Both totals start from zero in every frame.
- R5: pos_valid is a single-cycle pulse in the cycle after each boundary, starting from the second boundary. It carries the result of the frame that closed at the previous boundary. It never pulses inside a frame or after the first boundary.
- R6: For totals A and B with A+B > 0, pos = sign(A−B) · min(floor(|A−B|·2^15/(A+B)), 2^15−1), as a 16-bit two's-complement Q1.15 value, and pos_fault = 0.
- R7: When A+B = 0, pos keeps its previous value and pos_fault = 1. pos_fault changes only when pos_valid pulses.
- R8: During reset exc_code, pos, pos_valid and pos_fault are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adc_valid | input | 1 | The ADC sample in this cycle is valid |
| adc_coil | input | 1 | Coil tag: 0 = coil A, 1 = coil B |
| adc_data | input | ADC_W | Two's-complement ADC sample |
| exc_code | output | EXC_W | Signed sine code for the excitation DAC |
| pos | output | 16 | Signed Q1.15 position |
| pos_valid | output | 1 | One-cycle strobe for a new position |
| pos_fault | output | 1 | The last frame had a zero coil sum |

## Verification
The bench builds the block with PHASE_W = 6, QBITS = 4, PHASE_INC = 1 and EXC_DIV = 1. With these values the excitation steps every clock through all 64 phases, and every table entry and quadrant mirror is compared against the closed-form magnitude on each clock of the run. FRAME_CLKS = 64 and MAX_PER_COIL = 25 keep a frame short. This lets several dozen frames run: zero sums, one-coil-only frames that hit the ±(2^15−1) clamp, equal sums, full-scale negative samples, a sample on the closing cycle, and random counts and amplitudes. Every result is checked against the ratio worked out in the bench.

// File: rtl/lvdt_pkg.sv
package lvdt_pkg;

    localparam int POS_W  = 16;
    localparam int FRAC_W = 15;

    typedef enum logic {
        COIL_A = 1'b0,
        COIL_B = 1'b1
    } coil_e;

    // First-quadrant sine magnitude from a rational approximation.
    // x runs 0..q, where q table steps cover a quarter period.
    function automatic int qwave_val(input int x, input int q, input int amp);
        longint h;
        longint p;
        longint n;
        longint d;
        h = 2 * q;
        p = longint'(x) * (h - x);
        n = 16 * p * amp;
        d = 5 * h * h - 4 * p;
        return int'(n / d);
    endfunction

endpackage

// File: rtl/lvdt_sine_gen.sv
module lvdt_sine_gen
    import lvdt_pkg::*;
#(
    parameter int EXC_W     = 12,
    parameter int QBITS     = 4,
    parameter int PHASE_W   = 16,
    parameter int PHASE_INC = 256,
    parameter int EXC_DIV   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [EXC_W-1:0] code
);
    localparam int Q     = 1 << QBITS;
    localparam int AMP   = (1 << (EXC_W - 1)) - 1;
    localparam int DIV_W = (EXC_DIV > 1) ? $clog2(EXC_DIV) : 1;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [DIV_W-1:0]   cnt;
        logic [EXC_W-1:0]   code;
    } sg_t;

    sg_t cur_q, nxt_d;

    logic [EXC_W-1:0] lut [Q+1];

    for (genvar g = 0; g <= Q; g++) begin : g_lut
        localparam logic [EXC_W-1:0] ENTRY = EXC_W'(qwave_val(g, Q, AMP));
        assign lut[g] = ENTRY;
    end

    logic             tick_d;
    logic [1:0]       quad_d;
    logic [QBITS-1:0] addr_d;
    logic [QBITS:0]   idx_d;
    logic [EXC_W-1:0] mag_d;

    always_comb begin
        nxt_d  = cur_q;
        tick_d = (cur_q.cnt == DIV_W'(EXC_DIV - 1));
        quad_d = cur_q.phase[PHASE_W-1 -: 2];
        addr_d = cur_q.phase[PHASE_W-3 -: QBITS];
        idx_d  = quad_d[0] ? ((QBITS+1)'(Q) - {1'b0, addr_d}) : {1'b0, addr_d};
        mag_d  = lut[idx_d];
        if (tick_d) begin
            nxt_d.cnt   = '0;
            nxt_d.phase = cur_q.phase + PHASE_W'(PHASE_INC);
            nxt_d.code  = quad_d[1] ? (~mag_d + 1'b1) : mag_d;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign code = cur_q.code;

    // R1: the phase moves by exactly one increment per excitation step
    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_d |=> cur_q.phase == $past(cur_q.phase) + PHASE_W'(PHASE_INC));

    // R1: the code holds between steps
    p_code_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_d |=> $stable(cur_q.code));

    // R2: the code stays within the symmetric range and never takes the most negative value
    p_exc_symmetric_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.code != {1'b1, {(EXC_W-1){1'b0}}});

endmodule

// File: rtl/lvdt_frame_acc.sv
module lvdt_frame_acc
    import lvdt_pkg::*;
#(
    parameter int ADC_W      = 12,
    parameter int ACC_W      = 17,
    parameter int FRAME_CLKS = 12500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             smp_coil,
    input  logic [ADC_W-1:0] smp_data,
    output logic             frame_tick,
    output logic [ACC_W-1:0] close_a,
    output logic [ACC_W-1:0] close_b
);
    localparam int CNT_W = (FRAME_CLKS > 1) ? $clog2(FRAME_CLKS) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] acc_a;
        logic [ACC_W-1:0] acc_b;
    } fa_t;

    fa_t cur_q, nxt_d;

    logic [ADC_W-1:0] mag_d;
    logic [ACC_W-1:0] add_a_d;
    logic [ACC_W-1:0] add_b_d;

    always_comb begin
        nxt_d   = cur_q;
        mag_d   = smp_data[ADC_W-1] ? (~smp_data + 1'b1) : smp_data;
        add_a_d = cur_q.acc_a;
        add_b_d = cur_q.acc_b;
        if (smp_valid && coil_e'(smp_coil) == COIL_A) add_a_d = cur_q.acc_a + ACC_W'(mag_d);
        if (smp_valid && coil_e'(smp_coil) == COIL_B) add_b_d = cur_q.acc_b + ACC_W'(mag_d);
        frame_tick = (cur_q.cnt == CNT_W'(FRAME_CLKS - 1));
        if (frame_tick) begin
            nxt_d.cnt   = '0;
            nxt_d.acc_a = '0;
            nxt_d.acc_b = '0;
        end else begin
            nxt_d.cnt   = cur_q.cnt + 1'b1;
            nxt_d.acc_a = add_a_d;
            nxt_d.acc_b = add_b_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign close_a = add_a_d;
    assign close_b = add_b_d;

    // R4: every frame starts from empty totals
    p_acc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> (cur_q.acc_a == '0 && cur_q.acc_b == '0));

    // R3: an invalid sample leaves both totals untouched
    p_invalid_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !frame_tick) |=> ($stable(cur_q.acc_a) && $stable(cur_q.acc_b)));

endmodule

// File: rtl/lvdt_ratio_div.sv
module lvdt_ratio_div
    import lvdt_pkg::*;
#(
    parameter int SUM_W = 18,
    parameter int QUO_W = POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SUM_W-1:0] num_abs,
    input  logic             num_neg,
    input  logic [SUM_W-1:0] den,
    output logic             busy,
    output logic [QUO_W-1:0] quo,
    output logic             res_neg,
    output logic             res_zero
);
    localparam int CW = $clog2(QUO_W);

    typedef struct packed {
        logic             busy;
        logic [CW-1:0]    cnt;
        logic [SUM_W:0]   rem;
        logic [SUM_W-1:0] den;
        logic [QUO_W-1:0] quo;
        logic             neg;
        logic             zero;
    } dv_t;

    dv_t cur_q, nxt_d;

    logic           ge_d;
    logic [SUM_W:0] diff_d;

    always_comb begin
        nxt_d  = cur_q;
        ge_d   = cur_q.rem >= {1'b0, cur_q.den};
        diff_d = ge_d ? (cur_q.rem - {1'b0, cur_q.den}) : cur_q.rem;
        if (start) begin
            nxt_d.rem  = {1'b0, num_abs};
            nxt_d.den  = den;
            nxt_d.neg  = num_neg;
            nxt_d.zero = (den == '0);
            nxt_d.quo  = '0;
            nxt_d.busy = (den != '0);
            nxt_d.cnt  = CW'(QUO_W - 1);
        end else if (cur_q.busy) begin
            nxt_d.quo = {cur_q.quo[QUO_W-2:0], ge_d};
            nxt_d.rem = {diff_d[SUM_W-1:0], 1'b0};
            if (cur_q.cnt == '0) nxt_d.busy = 1'b0;
            else                 nxt_d.cnt  = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign busy     = cur_q.busy;
    assign quo      = cur_q.quo;
    assign res_neg  = cur_q.neg;
    assign res_zero = cur_q.zero;

    // R6: the partial remainder stays below twice the divisor while iterating
    p_rem_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.busy |-> cur_q.rem < {cur_q.den, 1'b0});

    // R6: a finished quotient never exceeds 1.0 in Q1.15
    p_quo_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_q.busy && $past(cur_q.busy)) |-> cur_q.quo <= QUO_W'(1 << (QUO_W - 1)));

endmodule

// File: rtl/lvdt_ratio_demod.sv
module lvdt_ratio_demod
    import lvdt_pkg::*;
#(
    parameter int EXC_W        = 12,
    parameter int QBITS        = 4,
    parameter int PHASE_W      = 16,
    parameter int PHASE_INC    = 256,
    parameter int EXC_DIV      = 4,
    parameter int ADC_W        = 12,
    parameter int FRAME_CLKS   = 12500,
    parameter int MAX_PER_COIL = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adc_valid,
    input  logic             adc_coil,
    input  logic [ADC_W-1:0] adc_data,
    output logic [EXC_W-1:0] exc_code,
    output logic [POS_W-1:0] pos,
    output logic             pos_valid,
    output logic             pos_fault
);
    localparam int ACC_W = ADC_W + $clog2(MAX_PER_COIL + 1);
    localparam int SUM_W = ACC_W + 1;

    logic             frame_tick;
    logic [ACC_W-1:0] close_a;
    logic [ACC_W-1:0] close_b;
    logic             div_busy;
    logic [POS_W-1:0] div_quo;
    logic             div_neg;
    logic             div_zero;

    logic [SUM_W-1:0] num_abs_d;
    logic             num_neg_d;
    logic [SUM_W-1:0] den_d;

    lvdt_sine_gen #(
        .EXC_W(EXC_W), .QBITS(QBITS), .PHASE_W(PHASE_W),
        .PHASE_INC(PHASE_INC), .EXC_DIV(EXC_DIV)
    ) u_sine (
        .clk(clk), .rst_n(rst_n), .code(exc_code)
    );

    lvdt_frame_acc #(
        .ADC_W(ADC_W), .ACC_W(ACC_W), .FRAME_CLKS(FRAME_CLKS)
    ) u_frame (
        .clk(clk), .rst_n(rst_n),
        .smp_valid(adc_valid), .smp_coil(adc_coil), .smp_data(adc_data),
        .frame_tick(frame_tick), .close_a(close_a), .close_b(close_b)
    );

    always_comb begin
        num_neg_d = close_b > close_a;
        num_abs_d = num_neg_d ? SUM_W'(close_b - close_a) : SUM_W'(close_a - close_b);
        den_d     = SUM_W'(close_a) + SUM_W'(close_b);
    end

    lvdt_ratio_div #(
        .SUM_W(SUM_W), .QUO_W(POS_W)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .start(frame_tick),
        .num_abs(num_abs_d), .num_neg(num_neg_d), .den(den_d),
        .busy(div_busy), .quo(div_quo), .res_neg(div_neg), .res_zero(div_zero)
    );

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             valid;
        logic             fault;
        logic             have;
    } ps_t;

    ps_t cur_q, nxt_d;

    logic [POS_W-1:0] mag_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        mag_d       = div_quo[POS_W-1] ? {1'b0, {(POS_W-1){1'b1}}} : div_quo;
        if (frame_tick) begin
            nxt_d.have = 1'b1;
            if (cur_q.have) begin
                nxt_d.valid = 1'b1;
                nxt_d.fault = div_zero;
                if (!div_zero) nxt_d.pos = div_neg ? (~mag_d + 1'b1) : mag_d;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign pos       = cur_q.pos;
    assign pos_valid = cur_q.valid;
    assign pos_fault = cur_q.fault;

    // R5: the strobe lasts exactly one cycle
    p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pos_valid |=> !pos_valid);

    // R5: the divider has finished before the next boundary consumes its result
    p_div_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> !div_busy);

    // R7: a zero-sum frame keeps the previous position
    p_hold_on_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_valid && pos_fault) |-> $stable(pos));

    // R7: the fault flag moves only together with the strobe
    p_fault_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pos_valid |-> $stable(pos_fault));

endmodule

// File: tb/sim_lvdt_ratio_demod.sv
module sim_lvdt_ratio_demod;
    localparam int FRAME = 64;
    localparam int MAXC  = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adc_valid = 1'b0;
    logic        adc_coil = 1'b0;
    logic [11:0] adc_data = '0;
    logic [11:0] exc_code;
    logic [15:0] pos;
    logic        pos_valid;
    logic        pos_fault;

    always #2 clk = ~clk;

    lvdt_ratio_demod #(
        .EXC_W(12), .QBITS(4), .PHASE_W(6), .PHASE_INC(1), .EXC_DIV(1),
        .ADC_W(12), .FRAME_CLKS(FRAME), .MAX_PER_COIL(MAXC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_coil(adc_coil),
        .adc_data(adc_data), .exc_code(exc_code), .pos(pos),
        .pos_valid(pos_valid), .pos_fault(pos_fault)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    int          edge_n = 0;
    logic [31:0] seed = 32'h1234_5678;
    longint      prev_sa = 0;
    longint      prev_sb = 0;
    bit          prev_ok = 1'b0;
    longint      held_pos = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_sine(input int p);
        int quad, a, i;
        longint pr, m;
        quad = (p >> 4) & 3;
        a    = p & 15;
        i    = (quad & 1) ? 16 - a : a;
        pr   = longint'(i) * (32 - i);
        m    = (2047 * 16 * pr) / (5 * 32 * 32 - 4 * pr);
        return (quad & 2) ? -int'(m) : int'(m);
    endfunction

    function int next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[30:8]);
    endfunction

    function int gen(input int amp);
        if (amp == 0) return 0;
        if (amp >= 4096) return -2048;
        if (amp < 0) return amp;
        return (next_rand() % (2 * amp + 1)) - amp;
    endfunction

    task automatic do_frame(input int na, input int nb, input int amp_a, input int amp_b, input bit edge_a);
        longint sa = 0;
        longint sb = 0;
        int stray = 0;
        longint n, d, q;
        for (int j = 0; j < FRAME; j++) begin
            int r;
            int v;
            r = next_rand();
            adc_valid = 1'b0;
            adc_coil  = r[0];
            adc_data  = 12'(r >> 3);
            if ((j % 2 == 0) && (j / 2 < na)) begin
                v = gen(amp_a);
                adc_valid = 1'b1; adc_coil = 1'b0; adc_data = 12'(v);
                sa += (v < 0) ? -v : v;
            end else if ((j % 2 == 1) && (j / 2 < nb)) begin
                v = gen(amp_b);
                adc_valid = 1'b1; adc_coil = 1'b1; adc_data = 12'(v);
                sb += (v < 0) ? -v : v;
            end else if (j == FRAME - 1 && edge_a) begin
                v = gen(amp_a);
                adc_valid = 1'b1; adc_coil = 1'b0; adc_data = 12'(v);
                sa += (v < 0) ? -v : v;
            end
            @(posedge clk);
            edge_n++;
            @(negedge clk);
            check($signed(exc_code) == exp_sine((edge_n - 1) % 64), "R1 R2 excitation code",
                  $signed(exc_code), exp_sine((edge_n - 1) % 64));
            if (j < FRAME - 1 && pos_valid) stray++;
        end
        adc_valid = 1'b0;
        check(stray == 0, "R5 no strobe inside a frame", stray, 0);
        if (prev_ok) begin
            check(pos_valid == 1'b1, "R5 strobe after boundary", pos_valid, 1);
            if (prev_sa + prev_sb == 0) begin
                check(pos_fault == 1'b1, "R7 fault on zero sum", pos_fault, 1);
                check($signed(pos) == held_pos, "R7 position held", $signed(pos), held_pos);
            end else begin
                n = (prev_sa > prev_sb) ? prev_sa - prev_sb : prev_sb - prev_sa;
                d = prev_sa + prev_sb;
                q = (n * 32768) / d;
                if (q > 32767) q = 32767;
                if (prev_sb > prev_sa) q = -q;
                check(pos_fault == 1'b0, "R7 fault cleared", pos_fault, 0);
                check($signed(pos) == q, "R3 R4 R6 ratio position", $signed(pos), q);
                held_pos = q;
            end
        end else begin
            check(pos_valid == 1'b0, "R5 no strobe at first boundary", pos_valid, 0);
        end
        prev_sa = sa;
        prev_sb = sb;
        prev_ok = 1'b1;
    endtask

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", edge_n, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(exc_code == '0, "R8 reset excitation", exc_code, 0);
        check(pos == '0, "R8 reset position", pos, 0);
        check(pos_valid == 1'b0, "R8 reset strobe", pos_valid, 0);
        check(pos_fault == 1'b0, "R8 reset fault", pos_fault, 0);
        rst_n = 1'b1;
        do_frame(0, 0, 0, 0, 1'b0);
        do_frame(0, 0, 0, 0, 1'b0);
        do_frame(20, 0, 2047, 0, 1'b1);
        do_frame(0, 20, 0, 2047, 1'b0);
        do_frame(24, 24, 4096, 4096, 1'b1);
        do_frame(10, 10, -300, -300, 1'b0);
        do_frame(10, 12, -300, -250, 1'b1);
        do_frame(0, 0, 0, 0, 1'b0);
        do_frame(5, 7, 1000, 1000, 1'b0);
        for (int k = 0; k < 40; k++) begin
            int r, amps[6];
            amps = '{0, 1, 50, 700, 2047, 4096};
            r = next_rand();
            do_frame(r % 25, (r >> 5) % 26, amps[(r >> 10) % 6], amps[(r >> 14) % 6], r[20]);
        end
        do_frame(0, 0, 0, 0, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule